// File: doc/BRIEF.md
# DMA Channel Arbiter with Preemption

This block chooses which DMA channel runs next. Channels are split into equal groups of consecutive indices. Group selection and channel selection each work in one of two modes. In fixed-priority mode the highest programmed priority wins. In round-robin mode a rotating search runs over the requesters. A request is evaluated in one clock cycle and registered as a candidate. The candidate is granted in the following cycle. The granted channel keeps the grant until the datapath reports, with a one-cycle pulse, that it has finished one major-loop iteration.

When both modes are fixed priority, a running channel that has preemption enabled can be suspended. This happens when a candidate with a strictly higher priority appears. The suspended channel keeps its active flag. The preempting channel runs one iteration, and then the suspended channel takes the grant back straight away. Only one level of suspension exists.

Top module: `dma_ch_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant_valid`, `preempt` and every bit of `ch_active` are 0.
- R2: A request level that is present before clock edge k, while the engine is idle and nothing else is pending, is granted with `grant_valid` at 1 after edge k+1 and not earlier.
- R3: With `grp_rr_mode`=0 and `ch_rr_mode`=0, the winner comes from the requesting group with the largest `grp_pri` field (bits [g*GRP_PRI_W +: GRP_PRI_W]). Inside that group the channel with the largest `ch_pri` field (bits [c*CH_PRI_W +: CH_PRI_W]) wins. Equal values go to the lower index. Channel c belongs to group c / (NUM_CH/NUM_GRP).
- R4: With `ch_rr_mode`=1, each group keeps a pointer to the offset it granted last. The search starts one offset past that pointer and wraps. At reset the search starts at offset 0.
- R5: With `grp_rr_mode`=1, groups are searched one past the group granted last, with wraparound. At reset the search starts at group 0.
- R6: With both modes 0, a running channel whose `ch_preempt_en` bit is 1 gives the grant to a candidate whose {group priority, channel priority} pair is strictly larger. At that point `preempt` becomes 1.
- R7: During a preemption the suspended channel's `ch_active` bit stays 1, so exactly two `ch_active` bits are 1.
- R8: An `iter_done` pulse during a preemption ends it at that edge. `preempt` returns to 0 and `grant_ch` returns to the suspended channel.
- R9: While `preempt` is 1, no further preemption occurs, whatever the priorities of new requests.
- R10: When either mode select is 1, the preempt-enable bits are ignored. A granted channel keeps the grant until `iter_done`.
- R11: Channels whose `ch_active` bit is 1 are not candidates. A running channel is never granted a second time while it runs.
- R12: An `iter_done` pulse while `grant_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_CH | Per-channel service request level |
| ch_pri | input | NUM_CH*CH_PRI_W | Per-channel priority, larger is higher |
| ch_preempt_en | input | NUM_CH | Per-channel permission to be preempted |
| grp_pri | input | NUM_GRP*GRP_PRI_W | Per-group priority, larger is higher |
| grp_rr_mode | input | 1 | 1 = round-robin group selection |
| ch_rr_mode | input | 1 | 1 = round-robin channel selection |
| iter_done | input | 1 | Pulse: the granted channel finished one major-loop iteration |
| grant_valid | output | 1 | A channel holds the grant |
| grant_ch | output | $clog2(NUM_CH) | Index of the granted channel |
| preempt | output | 1 | A suspended channel is waiting under a preemption |
| ch_active | output | NUM_CH | Running or suspended channels |

## Verification
A grant decision becomes visible two edges after the inputs that caused it: one edge registers the candidate and the next edge commits it to the running slot. A completion pulse acts at the next edge, so a resume or a release shows one edge after `iter_done`. The bench keeps a cycle-level reference model with the same two-stage timing. It changes inputs on the falling edge, advances the model at the rising edge, and compares every output at the following falling edge. Directed cases also check latency and preemption with fixed expected values at the exact edge counts.

// File: rtl/dma_arb_pkg.sv
// Package: shared mode encoding for the DMA channel arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dma_arb_pkg;
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_pick.sv
// Module: dma_pick
// Selects one of N requesters, either by largest key (ties go to the lower
// index) or by a rotating search that begins one past ptr.
// Assumes N >= 1; purely combinational.
module dma_pick
    import dma_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int KW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    vld,
    input  logic [N*KW-1:0] key,
    input  logic            rr_en,
    input  logic [IW-1:0]   ptr,
    output logic            any,
    output logic [IW-1:0]   win
);
    // Purpose: search the requesters in the order the selected mode gives.
    always_comb begin
        logic          found;
        logic [KW-1:0] best;
        int            idx;
        found = 1'b0;
        best  = '0;
        win   = '0;
        idx   = 0;
        if (arb_mode_e'(rr_en) == ARB_ROUND) begin
            for (int k = 0; k < N; k++) begin
                idx = (int'(ptr) + 1 + k) % N;
                if (!found && vld[idx]) begin
                    found = 1'b1;
                    win   = IW'(idx);
                end
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (vld[i] && (!found || key[i*KW +: KW] > best)) begin
                    found = 1'b1;
                    best  = key[i*KW +: KW];
                    win   = IW'(i);
                end
            end
        end
    end

    assign any = |vld;
endmodule

// File: rtl/dma_arb_select.sv
// Module: dma_arb_select
// First arbitration stage. Per-group channel pickers feed a group picker. The
// result is registered as the candidate, so the next stage sees it one edge
// later. The module also holds the round-robin pointers, which move on upd_vld.
// Assumes NUM_CH is a multiple of NUM_GRP; groups are contiguous index ranges.
module dma_arb_select #(
    parameter int NUM_CH    = 8,
    parameter int NUM_GRP   = 2,
    parameter int CH_PRI_W  = 3,
    parameter int GRP_PRI_W = 2,
    localparam int CPG   = NUM_CH / NUM_GRP,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int OFF_W = (CPG > 1) ? $clog2(CPG) : 1,
    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            req_m,
    input  logic [NUM_CH*CH_PRI_W-1:0]   ch_pri,
    input  logic [NUM_GRP*GRP_PRI_W-1:0] grp_pri,
    input  logic                         grp_rr,
    input  logic                         ch_rr,
    input  logic                         upd_vld,
    input  logic [CH_W-1:0]              upd_ch,
    output logic                         cand_vld,
    output logic [CH_W-1:0]              cand_ch
);
    logic [OFF_W-1:0] cptr_q  [NUM_GRP];
    logic [GRP_W-1:0] gptr_q;
    logic [OFF_W-1:0] grp_win [NUM_GRP];
    logic [NUM_GRP-1:0] grp_any;
    logic             any_d;
    logic [GRP_W-1:0] gwin;
    logic [CH_W-1:0]  cand_d;
    logic [GRP_W-1:0] upd_grp;
    logic [OFF_W-1:0] upd_off;

    // One channel picker per group, all using the channel mode.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        dma_pick #(.N(CPG), .KW(CH_PRI_W)) u_ch (
            .vld   (req_m[g*CPG +: CPG]),
            .key   (ch_pri[g*CPG*CH_PRI_W +: CPG*CH_PRI_W]),
            .rr_en (ch_rr),
            .ptr   (cptr_q[g]),
            .any   (grp_any[g]),
            .win   (grp_win[g])
        );
    end

    // Group picker over the groups that have at least one requester.
    dma_pick #(.N(NUM_GRP), .KW(GRP_PRI_W)) u_grp (
        .vld   (grp_any),
        .key   (grp_pri),
        .rr_en (grp_rr),
        .ptr   (gptr_q),
        .any   (any_d),
        .win   (gwin)
    );

    // Purpose: turn the group and offset into a flat channel index.
    always_comb begin
        cand_d  = CH_W'(gwin) * CH_W'(CPG) + CH_W'(grp_win[gwin]);
        upd_grp = GRP_W'(int'(upd_ch) / CPG);
        upd_off = OFF_W'(int'(upd_ch) % CPG);
    end

    // Purpose: register the candidate (first arbitration cycle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_vld <= 1'b0;
            cand_ch  <= '0;
        end else begin
            cand_vld <= any_d;
            cand_ch  <= cand_d;
        end
    end

    // Purpose: move the rotation pointers to the channel just granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gptr_q <= GRP_W'(NUM_GRP - 1);
            for (int g = 0; g < NUM_GRP; g++) cptr_q[g] <= OFF_W'(CPG - 1);
        end else if (upd_vld) begin
            gptr_q          <= upd_grp;
            cptr_q[upd_grp] <= upd_off;
        end
    end

    // A candidate always comes from a channel that was requesting and idle.
    AST_CAND_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld |-> |($past(req_m) & (NUM_CH'(1) << cand_ch))); // R11
endmodule

// File: rtl/dma_ch_arbiter.sv
// Module: dma_ch_arbiter (top)
// Second arbitration stage and run control. A registered candidate is granted
// when the engine is idle. Under fixed/fixed modes it can also preempt a
// preempt-enabled running channel of strictly lower priority. The suspended
// channel resumes on the preemptor's completion pulse.
// Assumes iter_done is a single-cycle pulse that refers to the granted channel.
module dma_ch_arbiter #(
    parameter int NUM_CH    = 8,
    parameter int NUM_GRP   = 2,
    parameter int CH_PRI_W  = 3,
    parameter int GRP_PRI_W = 2,
    localparam int CPG   = NUM_CH / NUM_GRP,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int KEY_W = GRP_PRI_W + CH_PRI_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            req,
    input  logic [NUM_CH*CH_PRI_W-1:0]   ch_pri,
    input  logic [NUM_CH-1:0]            ch_preempt_en,
    input  logic [NUM_GRP*GRP_PRI_W-1:0] grp_pri,
    input  logic                         grp_rr_mode,
    input  logic                         ch_rr_mode,
    input  logic                         iter_done,
    output logic                         grant_valid,
    output logic [CH_W-1:0]              grant_ch,
    output logic                         preempt,
    output logic [NUM_CH-1:0]            ch_active
);
    logic            run_vld, susp_vld;
    logic [CH_W-1:0] run_ch, susp_ch;
    logic            cand_vld;
    logic [CH_W-1:0] cand_ch;
    logic [NUM_CH-1:0] req_m;
    logic            take_idle, take_pre, preempt_ok;

    // Purpose: combined priority of a channel, group field on top.
    function automatic logic [KEY_W-1:0] prio_key(input logic [CH_W-1:0] c);
        int g;
        g = int'(c) / CPG;
        return {grp_pri[g*GRP_PRI_W +: GRP_PRI_W], ch_pri[int'(c)*CH_PRI_W +: CH_PRI_W]};
    endfunction

    // Purpose: flag the running and suspended channels.
    always_comb begin
        ch_active = '0;
        if (run_vld)  ch_active[run_ch]  = 1'b1;
        if (susp_vld) ch_active[susp_ch] = 1'b1;
    end

    assign req_m = req & ~ch_active;

    dma_arb_select #(
        .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP),
        .CH_PRI_W(CH_PRI_W), .GRP_PRI_W(GRP_PRI_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_m    (req_m),
        .ch_pri   (ch_pri),
        .grp_pri  (grp_pri),
        .grp_rr   (grp_rr_mode),
        .ch_rr    (ch_rr_mode),
        .upd_vld  (take_idle | take_pre),
        .upd_ch   (cand_ch),
        .cand_vld (cand_vld),
        .cand_ch  (cand_ch)
    );

    // Purpose: decide between an idle grant and a preemption this cycle.
    always_comb begin
        preempt_ok = run_vld && !susp_vld && !grp_rr_mode && !ch_rr_mode &&
                     ch_preempt_en[run_ch] && cand_vld &&
                     (prio_key(cand_ch) > prio_key(run_ch));
        take_idle  = !run_vld && cand_vld;
        take_pre   = preempt_ok && !iter_done;
    end

    // Purpose: running/suspended slots (second arbitration cycle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_vld  <= 1'b0;
            run_ch   <= '0;
            susp_vld <= 1'b0;
            susp_ch  <= '0;
        end else if (run_vld && iter_done) begin
            if (susp_vld) begin
                run_ch   <= susp_ch;
                susp_vld <= 1'b0;
            end else begin
                run_vld  <= 1'b0;
            end
        end else if (take_idle) begin
            run_vld <= 1'b1;
            run_ch  <= cand_ch;
        end else if (take_pre) begin
            susp_vld <= 1'b1;
            susp_ch  <= run_ch;
            run_ch   <= cand_ch;
        end
    end

    assign grant_valid = run_vld;
    assign grant_ch    = run_ch;
    assign preempt     = susp_vld;

    AST_SUSPENDED_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preempt) |-> ($countones(ch_active) == 2) && ch_active[$past(grant_ch)]); // R7
    AST_RESUME_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        preempt && iter_done |=> !preempt && grant_valid); // R8
    AST_SINGLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        preempt && !iter_done |=> preempt && $stable(grant_ch)); // R9
    AST_PREEMPT_FIXED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preempt) |-> !$past(grp_rr_mode) && !$past(ch_rr_mode)); // R10
    AST_RR_HOLDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !iter_done && (grp_rr_mode || ch_rr_mode)
        |=> grant_valid && $stable(grant_ch)); // R10
    AST_IDLE_DONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid && iter_done |=> !preempt); // R12
endmodule

// File: tb/sim_dma_ch_arbiter.sv
// Bench for dma_ch_arbiter. A cycle-level reference model is built from the
// requirements. Inputs change on the falling edge, the model advances at the
// rising edge, and outputs are compared on the next falling edge.
module sim_dma_ch_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8, NG = 2, CW = 3, GW = 2, CPG = NCH / NG;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] req = '0, pe = '0;
    logic [NCH*CW-1:0] ch_pri = '0;
    logic [NG*GW-1:0] grp_pri = '0;
    logic grp_rr = 1'b0, ch_rr = 1'b0, iter_done = 1'b0;
    logic grant_valid, preempt;
    logic [2:0] grant_ch;
    logic [NCH-1:0] ch_active;

    int n_chk = 0, n_fail = 0;
    bit m_cv, m_rv, m_sv;
    int m_cand, m_run, m_susp, m_gptr;
    int m_cptr [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ch_arbiter #(.NUM_CH(NCH), .NUM_GRP(NG), .CH_PRI_W(CW), .GRP_PRI_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ch_pri(ch_pri), .ch_preempt_en(pe),
        .grp_pri(grp_pri), .grp_rr_mode(grp_rr), .ch_rr_mode(ch_rr),
        .iter_done(iter_done), .grant_valid(grant_valid), .grant_ch(grant_ch),
        .preempt(preempt), .ch_active(ch_active));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int key_of(int c);
        return int'(grp_pri[(c/CPG)*GW +: GW]) * 16 + int'(ch_pri[c*CW +: CW]);
    endfunction

    function automatic logic [NCH-1:0] m_active();
        logic [NCH-1:0] a = '0;
        if (m_rv) a[m_run] = 1'b1;
        if (m_sv) a[m_susp] = 1'b1;
        return a;
    endfunction

    // Reference selection from the fixed and rotating rules.
    function automatic int model_pick(logic [NCH-1:0] rm);
        int g = -1, c = -1, best = -1;
        for (int k = 0; k < NG; k++) begin
            int gg = grp_rr ? (m_gptr + 1 + k) % NG : k;
            if (|rm[gg*CPG +: CPG]) begin
                if (grp_rr) begin
                    if (g < 0) g = gg;
                end else if (int'(grp_pri[gg*GW +: GW]) > best) begin
                    g = gg; best = int'(grp_pri[gg*GW +: GW]);
                end
            end
        end
        if (g < 0) return -1;
        best = -1;
        for (int k = 0; k < CPG; k++) begin
            int o = ch_rr ? (m_cptr[g] + 1 + k) % CPG : k;
            if (rm[g*CPG + o]) begin
                if (ch_rr) begin
                    if (c < 0) c = g*CPG + o;
                end else if (int'(ch_pri[(g*CPG+o)*CW +: CW]) > best) begin
                    c = g*CPG + o; best = int'(ch_pri[(g*CPG+o)*CW +: CW]);
                end
            end
        end
        return c;
    endfunction

    task automatic step(string tag);
        int nc, nrun, nsusp;
        bit nrv, nsv, upd;
        nc = model_pick(req & ~m_active());
        nrv = m_rv; nsv = m_sv; nrun = m_run; nsusp = m_susp; upd = 0;
        if (m_rv && iter_done) begin
            if (m_sv) begin nrun = m_susp; nsv = 0; end else nrv = 0;
        end else if (!m_rv && m_cv) begin
            nrv = 1; nrun = m_cand; upd = 1;
        end else if (m_rv && !m_sv && !grp_rr && !ch_rr && pe[m_run] && m_cv &&
                     key_of(m_cand) > key_of(m_run)) begin
            nsv = 1; nsusp = m_run; nrun = m_cand; upd = 1;
        end
        @(posedge clk);
        if (upd) begin m_gptr = m_cand / CPG; m_cptr[m_cand / CPG] = m_cand % CPG; end
        m_cv = (nc >= 0); m_cand = (nc < 0) ? 0 : nc;
        m_rv = nrv; m_sv = nsv; m_run = nrun; m_susp = nsusp;
        @(negedge clk);
        chk({tag, " grant_valid"}, int'(grant_valid), int'(m_rv));
        if (m_rv) chk({tag, " grant_ch"}, int'(grant_ch), m_run);
        chk({tag, " preempt"}, int'(preempt), int'(m_sv));
        chk({tag, " ch_active"}, int'(ch_active), int'(m_active()));
    endtask

    task automatic drain();
        req = '0;
        repeat (6) begin
            iter_done = m_rv;
            step("R11 drain");
        end
        iter_done = 1'b0;
    endtask

    task automatic set_chpri(int c, int v);
        ch_pri[c*CW +: CW] = CW'(v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_cv = 0; m_rv = 0; m_sv = 0; m_cand = 0; m_run = 0; m_susp = 0;
        m_gptr = NG - 1;
        for (int g = 0; g < NG; g++) m_cptr[g] = CPG - 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 grant_valid", int'(grant_valid), 0);
        chk("R1 preempt", int'(preempt), 0);
        chk("R1 ch_active", int'(ch_active), 0);
        rst_n = 1'b1;
        grp_pri = {2'd2, 2'd1};

        // R2: two-edge latency
        req = 8'h04;
        step("R2");
        chk("R2 early", int'(grant_valid), 0);
        step("R2");
        chk("R2 grant", int'(grant_valid), 1);
        chk("R2 channel", int'(grant_ch), 2);
        drain();

        // R3: group priority first, then channel priority, tie to lower index
        set_chpri(1, 7); set_chpri(5, 3); set_chpri(6, 3);
        req = 8'h62;
        step("R3"); step("R3");
        chk("R3 winner", int'(grant_ch), 5);
        drain();

        // R6/R7/R9/R8: preemption lifecycle
        pe = '1;
        req = 8'h02;
        step("R6"); step("R6");
        req = 8'h42;
        step("R6"); step("R6");
        chk("R6 preempt", int'(preempt), 1);
        chk("R6 grant", int'(grant_ch), 6);
        chk("R7 active", int'(ch_active), 'h42);
        set_chpri(7, 7);
        req = 8'hC2;
        repeat (3) step("R9");
        chk("R9 still", int'(grant_ch), 6);
        iter_done = 1'b1; req = 8'h82;
        step("R8");
        iter_done = 1'b0;
        chk("R8 resume", int'(grant_ch), 1);
        chk("R8 preempt", int'(preempt), 0);
        drain();

        // R10: round-robin disables preemption
        ch_rr = 1'b1;
        req = 8'h02;
        step("R10"); step("R10");
        req = 8'h42;
        repeat (3) step("R10");
        chk("R10 hold", int'(grant_ch), 1);
        chk("R10 no preempt", int'(preempt), 0);
        drain();

        // R12: completion pulse while idle
        iter_done = 1'b1;
        step("R12");
        iter_done = 1'b0;
        chk("R12 idle", int'(grant_valid), 0);

        // R4/R5: rotation with all channels requesting
        grp_rr = 1'b1; ch_rr = 1'b1;
        for (int i = 0; i < 12; i++) begin
            req = 8'hFF;
            iter_done = 1'b0; step("R4 R5");
            iter_done = m_rv; step("R4 R5");
        end
        drain();

        // Random mix checked against the model (R3 R4 R5 R6 R10 R11)
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                grp_rr = ($urandom % 3) == 0;
                ch_rr  = ($urandom % 3) == 0;
                ch_pri = NCH*CW'($urandom);
                grp_pri = NG*GW'($urandom);
                pe = NCH'($urandom);
            end
            req = NCH'($urandom) & NCH'($urandom);
            iter_done = ($urandom % 5) == 0;
            step("R6 R11 random");
        end
        iter_done = 1'b0;
        drain();

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule